// File: doc/BRIEF.md
# Debug Stall Control Register

This block is the control and status register a debug host uses to halt and release one CPU core. The host reaches it over a small register-access bus: a one-cycle request pulse carries the address, a write enable and write data, and the block answers with an acknowledge pulse and read data. Bit 0 of the control register drives the halt request to the core. Reads of that bit report the core's halted status as the core reports it, not the value last written.

A write to the control register does not complete until the core has entered the requested state. The block holds back the write acknowledge until the core's halted input matches the written value, so the host blocks for as long as the change takes. While that acknowledge is outstanding, new requests are dropped. When the core raises its breakpoint indicator, the block asserts the halt request by itself. A breakpoint that arrives during a pending resume overrides the resume.

Any other address is answered at once. It reads as zero, and a write to it changes nothing.

Top module: `dbg_stall_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `core_halt_o` is 0 and `req_ack` is 0.
- R2: A write to the control address with write-data bit 0 equal to 1 sets `core_halt_o` to 1 in the next cycle. Only bit 0 of the write data matters. `req_ack` pulses in the first cycle in which `core_halted_i` is 1.
- R3: A write to the control address with write-data bit 0 equal to 0 clears `core_halt_o` in the next cycle. Other data bits are ignored. `req_ack` pulses in the first cycle in which `core_halted_i` is 0.
- R4: If `core_halted_i` already equals the written bit, the write is acknowledged in the cycle after the request.
- R5: A read of the control address is acknowledged in the next cycle. Bit 0 of `req_rdata` holds `core_halted_i` as sampled in the request cycle, and all other bits are 0.
- R6: A cycle with `core_brk_i` high makes `core_halt_o` 1 in the next cycle.
- R7: If `core_brk_i` is high while a resume write is pending, `core_halt_o` returns to 1 and stays there. The pending write is acknowledged in the first cycle in which `core_halted_i` is 1.
- R8: While a write acknowledge is pending, requests are dropped. They produce no acknowledge, and a dropped write does not change `core_halt_o`.
- R9: A request to any address other than the control address is acknowledged in the next cycle with `req_rdata` equal to 0. A write to such an address leaves `core_halt_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle register request pulse |
| req_addr | input | ADDR_W | Register address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data; bit 0 is the halt bit |
| req_ack | output | 1 | Acknowledge pulse for an accepted request |
| req_rdata | output | DATA_W | Read data, valid with `req_ack` |
| core_halt_o | output | 1 | Halt request to the core |
| core_halted_i | input | 1 | Core reports that it is halted |
| core_brk_i | input | 1 | Core breakpoint indicator |

## Verification
The bench builds the block with a 3-bit address, 16-bit data and the control register at address 5. The non-zero control address means that a decode which only checks for address zero, or which drops upper address bits, is caught by the reads and writes to addresses 1 and 2. The 16-bit data lets the bench drive writes whose upper bits disagree with bit 0, which shows whether only bit 0 is used. It also lets the bench check that all upper read bits come back zero. Because the bench controls the core's halted input directly, it can set any delay before the core responds. This exposes the first cycle in which the acknowledge appears, the same-state case, requests dropped while an acknowledge is pending, and a breakpoint that overrides a resume.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    // Kind of request accepted in the current cycle
    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_CTRL_RD = 2'd1,
        ACC_CTRL_WR = 2'd2,
        ACC_OTHER   = 2'd3
    } acc_kind_e;

    // Write waiting for the core to match
    typedef struct packed {
        logic active;
        logic target;
    } wr_pend_t;

    function automatic acc_kind_e classify(input logic valid, input logic busy,
                                           input logic hit, input logic we);
        if (!valid || busy) return ACC_NONE;
        if (!hit)           return ACC_OTHER;
        return we ? ACC_CTRL_WR : ACC_CTRL_RD;
    endfunction

endpackage

// File: rtl/dsc_decode.sv
module dsc_decode
    import dsc_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic              busy_i,
    output acc_kind_e         kind_o
);

    logic hit;

    always_comb begin
        hit    = (req_addr == CTRL_ADDR);
        kind_o = classify(req_valid, busy_i, hit, req_we);
    end

endmodule

// File: rtl/dsc_halt_track.sv
module dsc_halt_track
    import dsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  acc_kind_e kind_i,
    input  logic      wr_bit_i,
    input  logic      core_halted_i,
    input  logic      core_brk_i,
    output logic      halt_o,
    output logic      busy_o,
    output logic      wr_ack_o
);

    logic     halt_q;
    wr_pend_t pend_q;

    assign halt_o   = halt_q;
    assign busy_o   = pend_q.active;
    assign wr_ack_o = pend_q.active && (core_halted_i == pend_q.target);

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
            pend_q <= '0;
        end else begin
            if (kind_i == ACC_CTRL_WR) begin
                halt_q        <= wr_bit_i;
                pend_q.active <= 1'b1;
                pend_q.target <= wr_bit_i;
            end else if (wr_ack_o) begin
                pend_q.active <= 1'b0;
            end
            // Breakpoint overrides any resume request
            if (core_brk_i) begin
                halt_q <= 1'b1;
                if (kind_i == ACC_CTRL_WR || pend_q.active)
                    pend_q.target <= 1'b1;
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!halt_o && !busy_o));

    // R2
    wr_sets_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == ACC_CTRL_WR && !core_brk_i) |=> (halt_o == $past(wr_bit_i)));

    // R6
    brk_forces_halt_chk: assert property (@(posedge clk) disable iff (rst)
        core_brk_i |=> halt_o);

    // R8
    pend_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !wr_ack_o && !core_brk_i) |=> (busy_o && $stable(halt_o)));

endmodule

// File: rtl/dsc_reply.sv
module dsc_reply
    import dsc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_kind_e         kind_i,
    input  logic              core_halted_i,
    input  logic              wr_ack_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic              imm_ack_q;
    logic [DATA_W-1:0] imm_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            imm_ack_q  <= 1'b0;
            imm_data_q <= '0;
        end else begin
            imm_ack_q  <= (kind_i == ACC_CTRL_RD) || (kind_i == ACC_OTHER);
            imm_data_q <= (kind_i == ACC_CTRL_RD) ? DATA_W'(core_halted_i) : '0;
        end
    end

    always_comb begin
        ack_o   = imm_ack_q | wr_ack_i;
        rdata_o = wr_ack_i ? '0 : imm_data_q;
    end

    // R5
    rd_reply_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == ACC_CTRL_RD) |=> (ack_o && rdata_o == DATA_W'($past(core_halted_i))));

    // R9
    other_reply_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == ACC_OTHER) |=> (ack_o && rdata_o == '0));

    // R8
    single_source_chk: assert property (@(posedge clk) disable iff (rst)
        !(imm_ack_q && wr_ack_i));

endmodule

// File: rtl/dbg_stall_ctrl.sv
module dbg_stall_ctrl
    import dsc_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] req_rdata,
    output logic              core_halt_o,
    input  logic              core_halted_i,
    input  logic              core_brk_i
);

    acc_kind_e kind;
    logic      busy;
    logic      wr_ack;
    logic      unused_wdata;

    assign unused_wdata = ^req_wdata[DATA_W-1:1];

    dsc_decode #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) decode_i (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_we    (req_we),
        .busy_i    (busy),
        .kind_o    (kind)
    );

    dsc_halt_track track_i (
        .clk           (clk),
        .rst           (rst),
        .kind_i        (kind),
        .wr_bit_i      (req_wdata[0]),
        .core_halted_i (core_halted_i),
        .core_brk_i    (core_brk_i),
        .halt_o        (core_halt_o),
        .busy_o        (busy),
        .wr_ack_o      (wr_ack)
    );

    dsc_reply #(
        .DATA_W (DATA_W)
    ) reply_i (
        .clk           (clk),
        .rst           (rst),
        .kind_i        (kind),
        .core_halted_i (core_halted_i),
        .wr_ack_i      (wr_ack),
        .ack_o         (req_ack),
        .rdata_o       (req_rdata)
    );

endmodule

// File: tb/dbg_stall_ctrl_tb.sv
module dbg_stall_ctrl_tb_top;

    localparam int            AW = 3;
    localparam int            DW = 16;
    localparam logic [AW-1:0] CA = 3'd5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_we = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ack;
    logic [DW-1:0] req_rdata;
    logic          core_halt_o;
    logic          core_halted = 1'b0;
    logic          core_brk = 1'b0;

    always #2 clk = ~clk;

    dbg_stall_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CTRL_ADDR(CA)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata), .req_ack(req_ack),
        .req_rdata(req_rdata), .core_halt_o(core_halt_o),
        .core_halted_i(core_halted), .core_brk_i(core_brk)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    int            exp_cyc_q[$];
    logic [DW-1:0] exp_dat_q[$];
    string         exp_tag_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_ack(input int at, input logic [DW-1:0] d, input string tag);
        exp_cyc_q.push_back(at);
        exp_dat_q.push_back(d);
        exp_tag_q.push_back(tag);
    endtask

    task automatic pulse(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
        req_valid = 1'b1;
        req_addr  = a;
        req_we    = w;
        req_wdata = d;
        step();
        req_valid = 1'b0;
    endtask

    // Monitor: pop the scoreboard on every acknowledge
    always @(negedge clk) begin
        if (!rst && req_ack) begin
            if (exp_cyc_q.size() == 0) begin
                chk(1'b0, "R8 unexpected ack cycle", cyc, -1);
            end else begin
                int            ec;
                logic [DW-1:0] ed;
                string         et;
                ec = exp_cyc_q.pop_front();
                ed = exp_dat_q.pop_front();
                et = exp_tag_q.pop_front();
                chk(cyc == ec, {et, " ack cycle"}, cyc, ec);
                chk(req_rdata === ed, {et, " rdata"}, int'(req_rdata), int'(ed));
            end
        end
    end

    initial begin
        #(4 * 20000);
        chk(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int c;
        repeat (3) step();
        chk(core_halt_o == 1'b0, "R1 halt in reset", core_halt_o, 0);
        chk(req_ack == 1'b0, "R1 ack in reset", req_ack, 0);
        rst = 1'b0;
        step();
        chk(core_halt_o == 1'b0, "R1 halt after reset", core_halt_o, 0);
        chk(req_ack == 1'b0, "R1 ack after reset", req_ack, 0);

        // R5 read while running
        c = cyc; expect_ack(c + 1, 16'h0000, "R5 read running");
        pulse(CA, 1'b0, 16'h0000);
        step();

        // R2 halt, core responds after 3 cycles
        c = cyc; expect_ack(c + 4, 16'h0000, "R2 halt write");
        pulse(CA, 1'b1, 16'h0001);
        chk(core_halt_o == 1'b1, "R2 halt request", core_halt_o, 1);
        repeat (3) step();
        core_halted = 1'b1;
        step();

        // R5 read while halted
        c = cyc; expect_ack(c + 1, 16'h0001, "R5 read halted");
        pulse(CA, 1'b0, 16'hFFFF);
        step();

        // R4 halt write while already halted
        c = cyc; expect_ack(c + 1, 16'h0000, "R4 halt same state");
        pulse(CA, 1'b1, 16'h8001);
        step();

        // R3 resume with upper bits set, core responds after 2 cycles
        c = cyc; expect_ack(c + 3, 16'h0000, "R3 resume write");
        pulse(CA, 1'b1, 16'hFFFE);
        chk(core_halt_o == 1'b0, "R3 halt released", core_halt_o, 0);
        repeat (2) step();
        core_halted = 1'b0;
        step();

        // R4 resume while already running
        c = cyc; expect_ack(c + 1, 16'h0000, "R4 resume same state");
        pulse(CA, 1'b1, 16'h0000);
        step();

        // R9 unmapped read and write
        c = cyc; expect_ack(c + 1, 16'h0000, "R9 unmapped read");
        pulse(3'd2, 1'b0, 16'h0000);
        c = cyc; expect_ack(c + 1, 16'h0000, "R9 unmapped write");
        pulse(3'd1, 1'b1, 16'h0001);
        chk(core_halt_o == 1'b0, "R9 unmapped write no halt", core_halt_o, 0);
        step();
        chk(core_halt_o == 1'b0, "R9 halt still clear", core_halt_o, 0);

        // R6 breakpoint halts the core
        core_brk = 1'b1;
        step();
        core_brk = 1'b0;
        chk(core_halt_o == 1'b1, "R6 breakpoint halt", core_halt_o, 1);
        core_halted = 1'b1;
        step();

        // R8 requests during a pending resume are dropped
        c = cyc; expect_ack(c + 3, 16'h0000, "R8 pending resume");
        pulse(CA, 1'b1, 16'h0000);
        chk(core_halt_o == 1'b0, "R8 resume request", core_halt_o, 0);
        pulse(CA, 1'b1, 16'h0001);
        chk(core_halt_o == 1'b0, "R8 dropped write", core_halt_o, 0);
        pulse(CA, 1'b0, 16'h0000);
        core_halted = 1'b0;
        step();
        chk(core_halt_o == 1'b0, "R8 halt after drop", core_halt_o, 0);
        step();

        // R7 breakpoint overrides a pending resume
        core_brk = 1'b1;
        step();
        core_brk = 1'b0;
        core_halted = 1'b1;
        step();
        c = cyc; expect_ack(c + 2, 16'h0000, "R7 brk over resume");
        pulse(CA, 1'b1, 16'h0000);
        chk(core_halt_o == 1'b0, "R7 resume requested", core_halt_o, 0);
        core_brk = 1'b1;
        step();
        core_brk = 1'b0;
        chk(core_halt_o == 1'b1, "R7 halt restored", core_halt_o, 1);
        step();
        chk(core_halt_o == 1'b1, "R7 halt held", core_halt_o, 1);

        // R9 unmapped read while halted still zero
        c = cyc; expect_ack(c + 1, 16'h0000, "R9 unmapped read halted");
        pulse(3'd4, 1'b0, 16'h0000);

        repeat (4) step();
        chk(exp_cyc_q.size() == 0, "R8 missing acks", exp_cyc_q.size(), 0);
        finish_run();
    end

endmodule